// File: doc/BRIEF.md
# Asynchronous Static Memory Cycle Sequencer

This block runs read and write cycles on one chip select of an external asynchronous memory bus. A request from the internal side (address, write data, byte enables and direction) is turned into a timed sequence of a setup phase, a pulse phase and a hold phase. Each phase has its own programmable length in clock cycles. Data-float wait states can be added to the sequence. An external wait input can stretch the pulse, either by freezing all timing or by holding the end of the pulse until the device reports ready.

The strobe that controls a write can be chosen: either the chip select or the write enable carries the pulse. On 16- and 32-bit buses the byte lanes are selected in one of two ways. One way drives lane-select strobes next to a shared write enable. The other way drives a separate write strobe for each lane. The cycle ends with a one-clock acknowledge. A read also returns the data on the bus, captured at the last clock of the pulse. The configuration inputs are assumed to stay constant while a cycle runs.

Top module: `smc_cycle_ctrl`

## Requirements
- R1: After reset, and in every idle cycle, all strobes (`cs_n`, `rd_n`, `we_n`, `lane_sel_n`, `lane_wr_n`) are high, `mem_doe` is low and `ack` is low.
- R2: With the wait input ignored, an access occupies exactly setup + pulse + hold (+ float) clock cycles. `ack` is then high for exactly one cycle. A programmed pulse of 0 counts as 1.
- R3: On a read, `cs_n` is low for setup + pulse + hold cycles and `rd_n` is low for the pulse cycles only, starting right after setup. `rdata` holds the value of `mem_din` at the last pulse clock, and `mem_doe` stays low.
- R4: On a write with `cfg_wr_by_we`=1, `cs_n` is low for the whole access and `we_n` is low for the pulse only. `mem_doe` is high and `mem_dout` carries the write data for the whole access.
- R5: On a write with `cfg_wr_by_we`=0, `cs_n` is low for the pulse only and `we_n` is low for the whole access.
- R6: When `cfg_float_en`=1, `cfg_float` extra cycles are added. On a write they come between setup and pulse, with the frame strobes kept active. On a read they come after hold, with all strobes high.
- R7: `cfg_wait_mode` codes 0 (off) and 1 (reserved) ignore `wait_n` completely.
- R8: Code 2 (frozen): a low `wait_n` sampled in a pulse cycle stops all phase timing for that cycle, and the access resumes where it stopped. A low `wait_n` sampled during setup or hold has no effect.
- R9: Code 3 (ready): `wait_n` is examined only in the last pulse cycle. If it is low, the pulse repeats until `wait_n` is sampled high.
- R10: Under wait codes 2 and 3, a programmed hold of 0 counts as 1. Under codes 0 and 1 a hold of 0 stays 0.
- R11: `cfg_bus_width` code 0 is an 8-bit bus, code 1 a 16-bit bus and codes 2 and 3 a 32-bit bus. The enabled lanes are `req_be` masked to lane 0, lanes 0–1 or lanes 0–3. On the 8-bit bus, `lane_sel_n` and `lane_wr_n` stay high and writes use `we_n`.
- R12: With `cfg_lane_style`=0 on a 16- or 32-bit bus, `lane_sel_n[i]` is low exactly when lane i is enabled and the access frame is active (the cycles in which `cs_n` is low for a read), for both reads and writes.
- R13: With `cfg_lane_style`=1 on a 16- or 32-bit bus, a write drives `lane_wr_n[i]` low for enabled lanes in place of `we_n`, which stays high. Reads drive no lane strobe, and `lane_sel_n` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_setup | input | CW | Setup length in cycles |
| cfg_pulse | input | CW | Pulse length in cycles (0 acts as 1) |
| cfg_hold | input | CW | Hold length in cycles |
| cfg_float | input | FW | Float wait states |
| cfg_float_en | input | 1 | Enables float wait states |
| cfg_wait_mode | input | 2 | 0 off, 1 reserved, 2 frozen, 3 ready |
| cfg_bus_width | input | 2 | 0 8-bit, 1 16-bit, 2/3 32-bit |
| cfg_lane_style | input | 1 | 0 lane selects, 1 per-lane write strobes |
| cfg_wr_by_we | input | 1 | 1 write enable carries the pulse, 0 chip select does |
| req | input | 1 | Access request, held until ack |
| req_we | input | 1 | 1 write, 0 read |
| req_addr | input | AW | Access address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 32 | Read data |
| mem_addr | output | AW | External address |
| mem_dout | output | 32 | External write data |
| mem_doe | output | 1 | Write data output enable |
| mem_din | input | 32 | External read data |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| we_n | output | 1 | Write enable, active low |
| lane_sel_n | output | 4 | Byte-lane selects, active low |
| lane_wr_n | output | 4 | Per-lane write strobes, active low |
| wait_n | input | 1 | External wait, low requests a stretch |

## Verification
The risky overlap is the wait input arriving in the same cycle as a phase boundary. One case is a wait that starts in the final setup cycle and continues into the first pulse cycle. The other is a ready-mode wait that lands on the last pulse clock, which is also the read-capture clock. The tests move a low-wait window across setup, the pulse interior, the pulse end and hold. They then compare the total cycle count, the read-strobe width and the captured data with values computed from the programmed lengths: only samples taken in pulse cycles may add cycles, and the data must be the value present on the real last pulse clock.

// File: rtl/smc_pkg.sv
package smc_pkg;
   localparam int LANES = 4;
   localparam int DW    = 8 * LANES;

   typedef enum logic [1:0] {
      PH_SETUP = 2'd0,
      PH_FLOAT = 2'd1,
      PH_PULSE = 2'd2,
      PH_HOLD  = 2'd3
   } phase_e;

   localparam logic [1:0] WAIT_OFF    = 2'd0;
   localparam logic [1:0] WAIT_FROZEN = 2'd2;
   localparam logic [1:0] WAIT_READY  = 2'd3;

   localparam logic [1:0] BUS_8  = 2'd0;
   localparam logic [1:0] BUS_16 = 2'd1;
endpackage

// File: rtl/smc_phase_seq.sv
module smc_phase_seq
   import smc_pkg::*;
#(
   parameter int CW = 6,
   parameter int FW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          we,
   input  logic [CW-1:0] len_setup,
   input  logic [CW-1:0] len_pulse,
   input  logic [CW-1:0] len_hold,
   input  logic [FW-1:0] len_float,
   input  logic          float_en,
   input  logic [1:0]    wait_mode,
   input  logic          wait_n,
   output logic          accept,
   output logic          busy,
   output phase_e        phase,
   output logic          capture,
   output logic          ack
);
   localparam int NPH = 4;
   localparam int PW  = $clog2(NPH);

   logic [PW-1:0] pos;
   logic [CW-1:0] cnt;
   phase_e        seq_a [NPH];
   logic [CW-1:0] len_a [NPH];
   logic [CW-1:0] pulse_eff, hold_eff, float_eff;
   logic          wait_on;
   logic [PW-1:0] first_idx, nxt_idx;
   logic          nxt_ok;
   logic          in_pulse, freeze, stretch, advance;

   assign wait_on   = (wait_mode == WAIT_FROZEN) || (wait_mode == WAIT_READY);
   assign pulse_eff = (len_pulse == '0) ? CW'(1) : len_pulse;
   assign hold_eff  = (wait_on && len_hold == '0) ? CW'(1) : len_hold;
   assign float_eff = float_en ? CW'(len_float) : '0;

   // writes put float states right after setup, reads put them last
   always_comb begin
      seq_a[0] = PH_SETUP;
      if (we) begin
         seq_a[1] = PH_FLOAT;
         seq_a[2] = PH_PULSE;
         seq_a[3] = PH_HOLD;
      end else begin
         seq_a[1] = PH_PULSE;
         seq_a[2] = PH_HOLD;
         seq_a[3] = PH_FLOAT;
      end
      for (int k = 0; k < NPH; k++) begin
         case (seq_a[k])
            PH_SETUP: len_a[k] = len_setup;
            PH_PULSE: len_a[k] = pulse_eff;
            PH_HOLD:  len_a[k] = hold_eff;
            default:  len_a[k] = float_eff;
         endcase
      end
   end

   // first non-empty phase, and the next non-empty phase after pos
   always_comb begin
      first_idx = '0;
      nxt_idx   = '0;
      nxt_ok    = 1'b0;
      for (int k = NPH - 1; k >= 0; k--) begin
         if (len_a[k] != '0) first_idx = PW'(k);
         if (k > int'(pos) && len_a[k] != '0) begin
            nxt_ok  = 1'b1;
            nxt_idx = PW'(k);
         end
      end
   end

   assign phase    = seq_a[pos];
   assign in_pulse = busy && (phase == PH_PULSE);
   assign freeze   = in_pulse && (wait_mode == WAIT_FROZEN) && !wait_n;
   assign stretch  = in_pulse && (wait_mode == WAIT_READY) && !wait_n && (cnt == '0);
   assign advance  = busy && !freeze && !stretch;
   assign accept   = start && !busy && !ack;
   assign capture  = advance && (cnt == '0) && (phase == PH_PULSE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         pos  <= '0;
         cnt  <= '0;
         ack  <= 1'b0;
      end else begin
         ack <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            pos  <= first_idx;
            cnt  <= len_a[first_idx] - CW'(1);
         end else if (advance) begin
            if (cnt != '0) begin
               cnt <= cnt - CW'(1);
            end else if (nxt_ok) begin
               pos <= nxt_idx;
               cnt <= len_a[nxt_idx] - CW'(1);
            end else begin
               busy <= 1'b0;
               pos  <= '0;
               ack  <= 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/smc_lane_map.sv
module smc_lane_map
   import smc_pkg::*;
#(
   parameter int NL = LANES
) (
   input  logic [1:0]    bus_width,
   input  logic [NL-1:0] be,
   output logic          wide,
   output logic [NL-1:0] lane_en
);
   assign wide = (bus_width != BUS_8);

   for (genvar i = 0; i < NL; i++) begin : g_lane
      logic reach;
      if (i == 0) begin : g_l0
         assign reach = 1'b1;
      end else if (i == 1) begin : g_l1
         assign reach = wide;
      end else begin : g_hi
         assign reach = wide && (bus_width != BUS_16);
      end
      assign lane_en[i] = be[i] && reach;
   end
endmodule

// File: rtl/smc_strobe_gen.sv
module smc_strobe_gen
   import smc_pkg::*;
#(
   parameter int NL = LANES
) (
   input  logic          busy,
   input  phase_e        phase,
   input  logic          we,
   input  logic          wr_by_we,
   input  logic          lane_style,
   input  logic          wide,
   input  logic [NL-1:0] lane_en,
   output logic          cs_n,
   output logic          rd_n,
   output logic          we_n,
   output logic [NL-1:0] lane_sel_n,
   output logic [NL-1:0] lane_wr_n,
   output logic          doe
);
   logic pulse, frame, wcmd, per_lane_wr, sel_style;

   assign pulse       = busy && (phase == PH_PULSE);
   assign frame       = busy && ((phase != PH_FLOAT) || we);
   assign wcmd        = we && (wr_by_we ? pulse : frame);
   assign per_lane_wr = lane_style && wide;
   assign sel_style   = !lane_style && wide;

   assign cs_n = !((we && !wr_by_we) ? pulse : frame);
   assign rd_n = !(!we && pulse);
   assign we_n = !(wcmd && !per_lane_wr);
   assign doe  = busy && we;

   for (genvar i = 0; i < NL; i++) begin : g_strb
      assign lane_sel_n[i] = !(frame && sel_style && lane_en[i]);
      assign lane_wr_n[i]  = !(wcmd && per_lane_wr && lane_en[i]);
   end
endmodule

// File: rtl/smc_cycle_ctrl.sv
module smc_cycle_ctrl
   import smc_pkg::*;
#(
   parameter int AW = 24,
   parameter int CW = 6,
   parameter int FW = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CW-1:0]    cfg_setup,
   input  logic [CW-1:0]    cfg_pulse,
   input  logic [CW-1:0]    cfg_hold,
   input  logic [FW-1:0]    cfg_float,
   input  logic             cfg_float_en,
   input  logic [1:0]       cfg_wait_mode,
   input  logic [1:0]       cfg_bus_width,
   input  logic             cfg_lane_style,
   input  logic             cfg_wr_by_we,
   input  logic             req,
   input  logic             req_we,
   input  logic [AW-1:0]    req_addr,
   input  logic [DW-1:0]    req_wdata,
   input  logic [LANES-1:0] req_be,
   output logic             ack,
   output logic [DW-1:0]    rdata,
   output logic [AW-1:0]    mem_addr,
   output logic [DW-1:0]    mem_dout,
   output logic             mem_doe,
   input  logic [DW-1:0]    mem_din,
   output logic             cs_n,
   output logic             rd_n,
   output logic             we_n,
   output logic [LANES-1:0] lane_sel_n,
   output logic [LANES-1:0] lane_wr_n,
   input  logic             wait_n
);
   if (AW < 1) begin : g_bad_aw
      $error("smc_cycle_ctrl: AW must be at least 1");
   end
   if (CW < 2) begin : g_bad_cw
      $error("smc_cycle_ctrl: CW must be at least 2");
   end
   if (FW < 1 || FW > CW) begin : g_bad_fw
      $error("smc_cycle_ctrl: FW must lie in 1..CW");
   end

   logic             accept, busy, capture;
   phase_e           phase;
   logic             we_q, we_eff, wide;
   logic [LANES-1:0] be_q, lane_en;

   assign we_eff = busy ? we_q : req_we;

   smc_phase_seq #(.CW(CW), .FW(FW)) i_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (req),
      .we        (we_eff),
      .len_setup (cfg_setup),
      .len_pulse (cfg_pulse),
      .len_hold  (cfg_hold),
      .len_float (cfg_float),
      .float_en  (cfg_float_en),
      .wait_mode (cfg_wait_mode),
      .wait_n    (wait_n),
      .accept    (accept),
      .busy      (busy),
      .phase     (phase),
      .capture   (capture),
      .ack       (ack)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_q     <= 1'b0;
         be_q     <= '0;
         mem_addr <= '0;
         mem_dout <= '0;
         rdata    <= '0;
      end else begin
         if (accept) begin
            we_q     <= req_we;
            be_q     <= req_be;
            mem_addr <= req_addr;
            mem_dout <= req_wdata;
         end
         if (capture) rdata <= mem_din;
      end
   end

   smc_lane_map #(.NL(LANES)) i_lanes (
      .bus_width (cfg_bus_width),
      .be        (be_q),
      .wide      (wide),
      .lane_en   (lane_en)
   );

   smc_strobe_gen #(.NL(LANES)) i_strb (
      .busy       (busy),
      .phase      (phase),
      .we         (we_q),
      .wr_by_we   (cfg_wr_by_we),
      .lane_style (cfg_lane_style),
      .wide       (wide),
      .lane_en    (lane_en),
      .cs_n       (cs_n),
      .rd_n       (rd_n),
      .we_n       (we_n),
      .lane_sel_n (lane_sel_n),
      .lane_wr_n  (lane_wr_n),
      .doe        (mem_doe)
   );
endmodule

// File: rtl/smc_cycle_chk.sv
module smc_cycle_chk #(
   parameter int NL = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic          cs_n,
   input logic          rd_n,
   input logic          we_n,
   input logic [NL-1:0] lane_sel_n,
   input logic [NL-1:0] lane_wr_n,
   input logic          mem_doe,
   input logic          wait_n,
   input logic [1:0]    cfg_wait_mode
);
   a_r2_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> !ack);

   a_r1_idle_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
      ack |-> (cs_n && rd_n && we_n && !mem_doe && (&lane_sel_n) && (&lane_wr_n)));

   a_r3_read_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_n |-> (!cs_n && !mem_doe && we_n));

   a_r13_lane_wr_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_wr_n != '1) |-> (we_n && rd_n && (&lane_sel_n)));

   a_r8_frozen_keeps_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wait_mode == 2'd2 && !rd_n && !wait_n) |=> !rd_n);

   a_r9_ready_keeps_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wait_mode == 2'd3 && !rd_n && !wait_n) |=> !rd_n);
endmodule

bind smc_cycle_ctrl smc_cycle_chk #(.NL(smc_pkg::LANES)) i_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ack           (ack),
   .cs_n          (cs_n),
   .rd_n          (rd_n),
   .we_n          (we_n),
   .lane_sel_n    (lane_sel_n),
   .lane_wr_n     (lane_wr_n),
   .mem_doe       (mem_doe),
   .wait_n        (wait_n),
   .cfg_wait_mode (cfg_wait_mode)
);

// File: tb/test_smc_cycle_ctrl.sv
module test_smc_cycle_ctrl;
   localparam int AW = 24;
   localparam logic [AW-1:0] ADDR = 24'h5A_C3_11;
   localparam logic [31:0] WD    = 32'hC0DE_1234;
   localparam logic [31:0] DIN_A = 32'hA5A5_0F0F;
   localparam logic [31:0] DIN_B = 32'h1111_2222;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [5:0] cfg_setup = 6'd2, cfg_pulse = 6'd3, cfg_hold = 6'd1;
   logic [3:0] cfg_float = 4'd2;
   logic cfg_float_en = 1'b0;
   logic [1:0] cfg_wait_mode = 2'd0, cfg_bus_width = 2'd2;
   logic cfg_lane_style = 1'b0, cfg_wr_by_we = 1'b1;
   logic req = 1'b0, req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [31:0] req_wdata = '0, mem_din = '0;
   logic [3:0] req_be = 4'hF;
   logic wait_n = 1'b1;
   logic ack, mem_doe, cs_n, rd_n, we_n;
   logic [31:0] rdata, mem_dout;
   logic [AW-1:0] mem_addr;
   logic [3:0] lane_sel_n, lane_wr_n;

   always #10 clk = ~clk;

   smc_cycle_ctrl #(.AW(AW), .CW(6), .FW(4)) i_smc_cycle_ctrl (
      .clk(clk), .rst_n(rst_n),
      .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse), .cfg_hold(cfg_hold),
      .cfg_float(cfg_float), .cfg_float_en(cfg_float_en),
      .cfg_wait_mode(cfg_wait_mode), .cfg_bus_width(cfg_bus_width),
      .cfg_lane_style(cfg_lane_style), .cfg_wr_by_we(cfg_wr_by_we),
      .req(req), .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
      .req_be(req_be), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
      .mem_dout(mem_dout), .mem_doe(mem_doe), .mem_din(mem_din),
      .cs_n(cs_n), .rd_n(rd_n), .we_n(we_n), .lane_sel_n(lane_sel_n),
      .lane_wr_n(lane_wr_n), .wait_n(wait_n)
   );

   int vectors = 0, fails = 0;
   int n_cyc, c_cs, c_rd, c_we, c_doe, c_lwr, f_rd, f_we, bad_addr, bad_dout;
   logic [3:0] and_sel, and_wr;
   logic [31:0] rd_val;

   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // one access; wait_n is low at negedges whose index lies in [wlo, whi]
   task automatic run_cycle(input logic we, input logic [3:0] be, input int wlo, input int whi);
      int k;
      bit done;
      k = 0; done = 0;
      c_cs = 0; c_rd = 0; c_we = 0; c_doe = 0; c_lwr = 0; f_rd = 0; f_we = 0;
      bad_addr = 0; bad_dout = 0; and_sel = 4'hF; and_wr = 4'hF; n_cyc = -1;
      @(negedge clk);
      req = 1'b1; req_we = we; req_addr = ADDR; req_wdata = WD; req_be = be;
      wait_n = !(0 >= wlo && 0 <= whi);
      mem_din = DIN_B;
      while (!done) begin
         @(posedge clk);
         k++;
         @(negedge clk);
         if (ack) begin
            n_cyc = k; done = 1;
         end else if (k > 300) begin
            done = 1;
         end else begin
            if (!cs_n) c_cs++;
            if (!rd_n) begin c_rd++; if (f_rd == 0) f_rd = k; end
            if (!we_n) begin c_we++; if (f_we == 0) f_we = k; end
            if (mem_doe) c_doe++;
            if (lane_wr_n != 4'hF) c_lwr++;
            and_sel &= lane_sel_n;
            and_wr  &= lane_wr_n;
            if (mem_addr != ADDR) bad_addr++;
            if (mem_doe && mem_dout != WD) bad_dout++;
            wait_n  = !(k >= wlo && k <= whi);
            mem_din = !rd_n ? DIN_A : DIN_B;
         end
      end
      req = 1'b0; wait_n = 1'b1;
      rd_val = rdata;
      @(negedge clk);
   endtask

   task automatic set_cfg(input int s, input int p, input int h, input logic fen,
                          input int wm, input int bw, input logic ls, input logic wbw);
      cfg_setup = 6'(s); cfg_pulse = 6'(p); cfg_hold = 6'(h); cfg_float_en = fen;
      cfg_wait_mode = 2'(wm); cfg_bus_width = 2'(bw); cfg_lane_style = ls; cfg_wr_by_we = wbw;
   endtask

   task automatic t_reset();
      chk("R1 cs_n idle", int'(cs_n), 1);
      chk("R1 rd_n idle", int'(rd_n), 1);
      chk("R1 we_n idle", int'(we_n), 1);
      chk("R1 lane_sel_n idle", int'(lane_sel_n), 15);
      chk("R1 lane_wr_n idle", int'(lane_wr_n), 15);
      chk("R1 doe idle", int'(mem_doe), 0);
      chk("R1 ack idle", int'(ack), 0);
   endtask

   task automatic t_read_widths();
      for (int bw = 0; bw < 3; bw++) begin
         set_cfg(2, 3, 1, 0, 0, bw, 0, 1);
         run_cycle(1'b0, 4'hF, -1, -2);
         chk("R2 read length", n_cyc, 7);
         chk("R3 cs low", c_cs, 6);
         chk("R3 rd low", c_rd, 3);
         chk("R3 rd start", f_rd, 3);
         chk("R3 doe off", c_doe, 0);
         chk("R3 rdata", int'(rd_val == DIN_A), 1);
         chk("R3 addr", bad_addr, 0);
         chk("R11 R12 lane select", int'(and_sel), bw == 0 ? 15 : (bw == 1 ? 12 : 0));
         chk("R1 back to idle", int'(cs_n & rd_n), 1);
      end
   endtask

   task automatic t_pulse_zero();
      set_cfg(2, 0, 1, 0, 0, 2, 0, 1);
      run_cycle(1'b0, 4'hF, -1, -2);
      chk("R2 zero pulse length", n_cyc, 5);
      chk("R2 zero pulse rd", c_rd, 1);
   endtask

   task automatic t_write_we();
      set_cfg(2, 3, 1, 0, 0, 2, 0, 1);
      run_cycle(1'b1, 4'b1010, -1, -2);
      chk("R2 write length", n_cyc, 7);
      chk("R4 cs whole", c_cs, 6);
      chk("R4 we pulse", c_we, 3);
      chk("R4 we start", f_we, 3);
      chk("R4 doe whole", c_doe, 6);
      chk("R4 dout", bad_dout, 0);
      chk("R12 write lanes", int'(and_sel), 5);
      chk("R4 no read", c_rd, 0);
   endtask

   task automatic t_write_cs();
      set_cfg(2, 3, 1, 0, 0, 1, 0, 0);
      run_cycle(1'b1, 4'hF, -1, -2);
      chk("R5 length", n_cyc, 7);
      chk("R5 cs pulse", c_cs, 3);
      chk("R5 we whole", c_we, 6);
      chk("R11 16-bit lanes", int'(and_sel), 12);
   endtask

   task automatic t_float();
      set_cfg(2, 3, 1, 1, 0, 2, 0, 1);
      run_cycle(1'b1, 4'hF, -1, -2);
      chk("R6 write float length", n_cyc, 9);
      chk("R6 write float before pulse", f_we, 5);
      chk("R6 write cs through float", c_cs, 8);
      run_cycle(1'b0, 4'hF, -1, -2);
      chk("R6 read float length", n_cyc, 9);
      chk("R6 read cs excludes float", c_cs, 6);
      chk("R6 read rd start", f_rd, 3);
   endtask

   task automatic t_wait_ignored();
      for (int m = 0; m < 2; m++) begin
         set_cfg(2, 3, 1, 0, m, 2, 0, 1);
         run_cycle(1'b0, 4'hF, 0, 1000);
         chk("R7 wait ignored length", n_cyc, 7);
         chk("R7 wait ignored rd", c_rd, 3);
      end
   endtask

   task automatic t_frozen();
      set_cfg(2, 3, 1, 0, 2, 2, 0, 1);
      run_cycle(1'b0, 4'hF, 1, 4);
      chk("R8 frozen across setup edge", n_cyc, 9);
      chk("R8 frozen rd width", c_rd, 5);
      chk("R8 frozen rdata", int'(rd_val == DIN_A), 1);
      run_cycle(1'b0, 4'hF, 0, 1);
      chk("R8 setup wait ignored", n_cyc, 7);
      run_cycle(1'b0, 4'hF, 6, 6);
      chk("R8 hold wait ignored", n_cyc, 7);
   endtask

   task automatic t_ready();
      set_cfg(2, 3, 1, 0, 3, 2, 0, 1);
      run_cycle(1'b0, 4'hF, 1, 7);
      chk("R9 ready stretch length", n_cyc, 10);
      chk("R9 ready rd width", c_rd, 6);
      chk("R9 ready rdata", int'(rd_val == DIN_A), 1);
      run_cycle(1'b0, 4'hF, 1, 4);
      chk("R9 mid-pulse wait ignored", n_cyc, 7);
   endtask

   task automatic t_hold_min();
      set_cfg(2, 3, 0, 0, 3, 2, 0, 1);
      run_cycle(1'b0, 4'hF, -1, -2);
      chk("R10 hold forced to one", n_cyc, 7);
      set_cfg(2, 3, 0, 0, 2, 2, 0, 1);
      run_cycle(1'b1, 4'hF, -1, -2);
      chk("R10 frozen hold forced", n_cyc, 7);
      set_cfg(2, 3, 0, 0, 0, 2, 0, 1);
      run_cycle(1'b0, 4'hF, -1, -2);
      chk("R10 hold zero kept", n_cyc, 6);
   endtask

   task automatic t_byte_write();
      set_cfg(2, 3, 1, 0, 0, 2, 1, 1);
      run_cycle(1'b1, 4'b0101, -1, -2);
      chk("R13 we unused", c_we, 0);
      chk("R13 lane write pattern", int'(and_wr), 10);
      chk("R13 lane write width", c_lwr, 3);
      chk("R13 no lane select", int'(and_sel), 15);
      set_cfg(2, 3, 1, 0, 0, 1, 1, 1);
      run_cycle(1'b1, 4'hF, -1, -2);
      chk("R13 R11 16-bit lane writes", int'(and_wr), 12);
      run_cycle(1'b0, 4'hF, -1, -2);
      chk("R13 read no lane strobes", int'(and_sel & and_wr), 15);
      chk("R13 read rd", c_rd, 3);
      set_cfg(2, 3, 1, 0, 0, 0, 1, 1);
      run_cycle(1'b1, 4'hF, -1, -2);
      chk("R11 8-bit uses we", c_we, 3);
      chk("R11 8-bit no lane write", int'(and_wr), 15);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_read_widths();
      t_pulse_zero();
      t_write_we();
      t_write_cs();
      t_float();
      t_wait_ignored();
      t_frozen();
      t_ready();
      t_hold_min();
      t_byte_write();
      summary();
      $finish;
   end
endmodule